// File: doc/BRIEF.md
# Serial Register Bank Slave

This block is a two-wire serial slave that gives a bus master byte access to a 64-entry register space. The space holds timekeeping bytes, control and watchdog bytes, alarm bytes, a square-wave setting and general-purpose RAM. It does not count time or compare alarms: it only stores the bytes and moves them over the bus. The clock and data lines reach it already synchronised to the system clock. The block never drives the data line high. Its only bus output is an enable that pulls the line low.

A write transfer addresses the device, sends one byte that loads the internal pointer, and then sends data bytes. Each data byte lands at the pointer and advances it. A read transfer streams bytes from the pointer onward, most significant bit first, until the master refuses a byte. The pointer keeps its value between transfers. A master can therefore set it in a write transfer and then read from there after a repeated START.

A power-fail input takes priority over everything else. When it is high, the transfer in progress is dropped, the pointer returns to zero, the data line is released at once, and all bus activity is ignored until the input falls again.

Top module: `serial_regbank`

## Requirements
- R1: A falling data line while the clock is high (START) begins address reception from any state. A rising data line while the clock is high (STOP) returns the slave to idle with the data line released.
- R2: An address byte of D0h (write) or D1h (read), i.e. 7-bit address 68h plus the direction bit as bit 0, is acknowledged by pulling the data line low for the ninth clock.
- R3: An address byte with any other 7-bit address is not acknowledged. Every later byte up to the next START is also not acknowledged and stores nothing.
- R4: The first byte after a write address loads its low six bits into the pointer and is acknowledged.
- R5: Every further byte of a write transfer is stored at the pointer and acknowledged, and the pointer then advances by one.
- R6: In a read transfer the byte at the pointer is sent most significant bit first. Data-line drive changes only while the clock is low. The pointer advances after each byte, and a master acknowledge (data low on the ninth clock) starts the next byte.
- R7: A master non-acknowledge (data high on the ninth clock) ends the read. The slave then leaves the line released until the next START.
- R8: The pointer wraps from 63 to 0, both when writing and when reading.
- R9: Locations 16, 17 and 18 are reserved. Writes to them are acknowledged and discarded, and they read as 00h.
- R10: Raising the power-fail input releases the data line at once, aborts any transfer, and sets the pointer to 0.
- R11: While power-fail is high, no START, byte or acknowledge is recognised and no location changes.
- R12: After reset the data line is released, the pointer is 0 and every location reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line, already synchronised |
| sda_i | input | 1 | Serial data line as seen on the bus, already synchronised |
| pwr_fail | input | 1 | Power-fail indication, high while supply is out of tolerance |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
The hardest case is a power failure while the slave itself is pulling the line low. It is hardest to reach because the slave holds the line for only one clock period, during an acknowledge. The bench raises power-fail in the middle of the high phase of the acknowledge clock and samples the line before the clock falls. A second sequence raises power-fail midway through a data byte and keeps clocking the rest of the byte, so the stray edges reach a slave that must ignore them. A later pointer-free read then shows that the pointer went back to zero. A third sequence runs a whole write transfer while power-fail is held high and then reads the target location back unchanged.

// File: rtl/sregbank_pkg.sv
package sregbank_pkg;

    localparam int         DEPTH    = 64;
    localparam int         AW       = $clog2(DEPTH);
    localparam logic [6:0] DEV_ADDR = 7'h68;
    localparam int         RSV_LO   = 16;
    localparam int         RSV_HI   = 18;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACKOUT,
        ST_SEND,
        ST_ACKIN
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_PTR,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic is_reserved(input int unsigned idx);
        return (idx >= RSV_LO) && (idx <= RSV_HI);
    endfunction

endpackage

// File: rtl/sb_cond_detect.sv
module sb_cond_detect
    import sregbank_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pwr_fail,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    // previous line levels keep tracking during power-fail so no false
    // edge appears when it is released
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.start = ~pwr_fail & scl_q & scl_i & sda_q & ~sda_i;
        ev.stop  = ~pwr_fail & scl_q & scl_i & ~sda_q & sda_i;
        ev.rise  = ~pwr_fail & ~scl_q & scl_i;
        ev.fall  = ~pwr_fail & scl_q & ~scl_i;
        ev.sda   = sda_i;
    end

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sregbank_pkg::*;
#(
    parameter int         DEPTH    = sregbank_pkg::DEPTH,
    parameter logic [6:0] DEV_ADDR = sregbank_pkg::DEV_ADDR,
    localparam int        AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_fail,
    input  bus_ev_t       ev,
    input  logic [7:0]    rd_data,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] ptr,
    output logic          sda_oe
);

    bus_st_e    st;
    phase_e     phase;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic       rw;
    logic       nack;
    logic       byte_in;
    logic       drive;

    assign byte_in = (st == ST_RECV) && ev.fall && (cnt == 4'd8);

    always_ff @(posedge clk) begin
        if (rst || pwr_fail) begin
            st    <= ST_IDLE;
            phase <= PH_DEV;
            cnt   <= '0;
            shreg <= '0;
            rw    <= 1'b0;
            nack  <= 1'b0;
            ptr   <= '0;
        end else if (ev.start) begin
            st    <= ST_RECV;
            phase <= PH_DEV;
            cnt   <= '0;
        end else if (ev.stop) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_RECV: begin
                    if (ev.rise && cnt != 4'd8) begin
                        shreg <= {shreg[6:0], ev.sda};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_in) begin
                        cnt <= '0;
                        unique case (phase)
                            PH_DEV: begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    st <= ST_ACKOUT;
                                    rw <= shreg[0];
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                            PH_PTR: begin
                                ptr <= shreg[AW-1:0];
                                st  <= ST_ACKOUT;
                            end
                            default: begin
                                ptr <= ptr + 1'b1;
                                st  <= ST_ACKOUT;
                            end
                        endcase
                    end
                end
                ST_ACKOUT: begin
                    if (ev.fall) begin
                        cnt <= '0;
                        if (phase == PH_DEV && rw) begin
                            st    <= ST_SEND;
                            shreg <= rd_data;
                        end else begin
                            st    <= ST_RECV;
                            phase <= (phase == PH_DEV) ? PH_PTR : PH_DATA;
                        end
                    end
                end
                ST_SEND: begin
                    if (ev.fall) begin
                        if (cnt == 4'd7) begin
                            st  <= ST_ACKIN;
                            cnt <= '0;
                        end else begin
                            shreg <= {shreg[6:0], 1'b0};
                            cnt   <= cnt + 4'd1;
                        end
                    end
                end
                ST_ACKIN: begin
                    if (ev.rise) begin
                        nack <= ev.sda;
                        ptr  <= ptr + 1'b1;
                    end else if (ev.fall) begin
                        if (nack) begin
                            st <= ST_IDLE;
                        end else begin
                            st    <= ST_SEND;
                            shreg <= rd_data;
                            cnt   <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign wr_en   = byte_in && (phase == PH_DATA);
    assign wr_data = shreg;

    always_comb begin
        drive = 1'b0;
        if (st == ST_ACKOUT)   drive = 1'b1;
        else if (st == ST_SEND) drive = ~shreg[7];
    end

    assign sda_oe = drive & ~pwr_fail;

endmodule

// File: rtl/sb_regbank.sv
module sb_regbank #(
    parameter int  DEPTH  = sregbank_pkg::DEPTH,
    parameter int  RSV_LO = sregbank_pkg::RSV_LO,
    parameter int  RSV_HI = sregbank_pkg::RSV_HI,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        if (i >= RSV_LO && i <= RSV_HI) begin : g_rsv
            assign cells[i] = 8'h00;
        end else begin : g_reg
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= 8'h00;
                else if (wr_en && wr_addr == AW'(i))
                    q <= wr_data;
            end
            assign cells[i] = q;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
    import sregbank_pkg::*;
#(
    parameter int         DEPTH    = sregbank_pkg::DEPTH,
    parameter logic [6:0] DEV_ADDR = sregbank_pkg::DEV_ADDR,
    parameter int         RSV_LO   = sregbank_pkg::RSV_LO,
    parameter int         RSV_HI   = sregbank_pkg::RSV_HI
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic pwr_fail,
    output logic sda_oe
);

    localparam int AW = $clog2(DEPTH);

    bus_ev_t       ev;
    logic          wr_en;
    logic [7:0]    wr_data;
    logic [AW-1:0] ptr;
    logic [7:0]    rd_data;

    sb_cond_detect u_cond (
        .clk      (clk),
        .rst      (rst),
        .pwr_fail (pwr_fail),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .ev       (ev)
    );

    sb_ctrl #(
        .DEPTH    (DEPTH),
        .DEV_ADDR (DEV_ADDR)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .pwr_fail (pwr_fail),
        .ev       (ev),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ptr      (ptr),
        .sda_oe   (sda_oe)
    );

    sb_regbank #(
        .DEPTH  (DEPTH),
        .RSV_LO (RSV_LO),
        .RSV_HI (RSV_HI)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/sb_checker.sv
module sb_checker
    import sregbank_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          scl_i,
    input logic          sda_i,
    input logic          pwr_fail,
    input logic          sda_oe,
    input logic [AW-1:0] ptr,
    input logic          wr_en,
    input logic [7:0]    rd_data
);

    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_i;
            sda_p <= sda_i;
        end
    end

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!pwr_fail && scl_p && scl_i && !sda_p && sda_i) |=> !sda_oe);

    // R6
    drive_while_low_chk: assert property (@(posedge clk) disable iff (rst || pwr_fail)
        (scl_p && scl_i) |-> $stable(sda_oe));

    // R5
    ptr_advance_chk: assert property (@(posedge clk) disable iff (rst || pwr_fail)
        wr_en |=> (ptr == AW'($past(ptr) + 1'b1)));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        is_reserved(int'(ptr)) |-> (rd_data == 8'h00));

    // R10
    pf_ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> (ptr == '0));

    // R11
    pf_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |-> !wr_en);

endmodule

bind serial_regbank sb_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .pwr_fail (pwr_fail),
    .sda_oe   (sda_oe),
    .ptr      (ptr),
    .wr_en    (wr_en),
    .rd_data  (rd_data)
);

// File: tb/tb_serial_regbank.sv
`timescale 1ns/1ps
module tb_serial_regbank;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic pwr_fail = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int checks = 0;
    int errors = 0;

    string exp_tag[$];
    int    exp_val[$];
    int    obs_val[$];

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    serial_regbank dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .pwr_fail (pwr_fail),
        .sda_oe   (sda_oe)
    );

    // monitor: compares observations against expectations in order
    always @(negedge clk) begin
        if (obs_val.size() > 0 && exp_val.size() > 0) begin
            string t;
            int e;
            int a;
            t = exp_tag.pop_front();
            e = exp_val.pop_front();
            a = obs_val.pop_front();
            checks++;
            if (a != e) begin
                errors++;
                $display("FAIL %s: actual %0h expected %0h", t, a, e);
            end
        end
    end

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic check(input string tag, input int expv, input int act);
        exp_tag.push_back(tag);
        exp_val.push_back(expv);
        obs_val.push_back(act);
    endtask

    task automatic bus_start();
        if (!scl) begin
            sda_m = 1'b1; half();
            scl = 1'b1;   half();
        end
        sda_m = 1'b0; half();
        scl = 1'b0;   half();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half();
        scl = 1'b1;   half();
        sda_m = 1'b1; half();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; half();
        scl = 1'b1; half();
        scl = 1'b0; @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1; half();
        scl = 1'b1; repeat (2) @(negedge clk);
        check(tag, int'(exp_ack), int'(sda_bus == 1'b0));
        repeat (2) @(negedge clk);
        scl = 1'b0; @(negedge clk);
    endtask

    task automatic read_byte(input bit mack, input logic [7:0] expv, input string tag);
        logic [7:0] d;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            half();
            scl = 1'b1; repeat (2) @(negedge clk);
            d[i] = sda_bus;
            repeat (2) @(negedge clk);
            scl = 1'b0;
        end
        @(negedge clk);
        sda_m = mack ? 1'b0 : 1'b1; half();
        scl = 1'b1; half();
        scl = 1'b0; @(negedge clk);
        sda_m = 1'b1;
        check(tag, int'(expv), int'(d));
    endtask

    task automatic set_ptr(input logic [7:0] p, input string tag);
        bus_start();
        write_byte(8'hD0, 1'b1, tag);
        write_byte(p, 1'b1, tag);
    endtask

    task automatic read_from(input logic [7:0] p, input string tag);
        set_ptr(p, tag);
        bus_start();
        write_byte(8'hD1, 1'b1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        check("R12 sda released", 0, int'(sda_oe));
        bus_start();
        write_byte(8'hD1, 1'b1, "R2 read address ack");
        read_byte(1'b0, 8'h00, "R12 location 0 after reset");
        bus_stop();
        check("R1 released after stop", 0, int'(sda_oe));

        // R4 R5: pointer load and sequential write
        set_ptr(8'h05, "R4 pointer byte ack");
        write_byte(8'hA1, 1'b1, "R5 data ack");
        write_byte(8'hB2, 1'b1, "R5 data ack");
        write_byte(8'hC3, 1'b1, "R5 data ack");
        bus_stop();

        // R6 R7: read back with repeated start, NACK ends
        read_from(8'h05, "R1 repeated start");
        read_byte(1'b1, 8'hA1, "R6 read byte 0");
        read_byte(1'b1, 8'hB2, "R6 read byte 1");
        read_byte(1'b0, 8'hC3, "R6 read byte 2");
        read_byte(1'b0, 8'hFF, "R7 no drive after nack");
        bus_stop();

        // R8: wrap on write and read
        set_ptr(8'h3E, "R8 pointer");
        write_byte(8'h11, 1'b1, "R8 data ack");
        write_byte(8'h22, 1'b1, "R8 data ack");
        write_byte(8'h33, 1'b1, "R8 data ack");
        bus_stop();
        read_from(8'h3E, "R8 read setup");
        read_byte(1'b1, 8'h11, "R8 read 62");
        read_byte(1'b1, 8'h22, "R8 read 63");
        read_byte(1'b0, 8'h33, "R8 read wrapped 0");
        bus_stop();

        // R9: reserved locations
        set_ptr(8'h0F, "R9 pointer");
        write_byte(8'h5A, 1'b1, "R9 ack 15");
        write_byte(8'h77, 1'b1, "R9 ack reserved 16");
        write_byte(8'h88, 1'b1, "R9 ack reserved 17");
        write_byte(8'h99, 1'b1, "R9 ack reserved 18");
        write_byte(8'h6C, 1'b1, "R9 ack 19");
        bus_stop();
        read_from(8'h0F, "R9 read setup");
        read_byte(1'b1, 8'h5A, "R9 read 15");
        read_byte(1'b1, 8'h00, "R9 read 16");
        read_byte(1'b1, 8'h00, "R9 read 17");
        read_byte(1'b1, 8'h00, "R9 read 18");
        read_byte(1'b0, 8'h6C, "R9 read 19");
        bus_stop();

        // R3: wrong device address
        set_ptr(8'h20, "R3 setup");
        write_byte(8'h42, 1'b1, "R3 setup data");
        bus_stop();
        bus_start();
        write_byte(8'hA0, 1'b0, "R3 no ack for address");
        write_byte(8'h20, 1'b0, "R3 no ack later byte");
        write_byte(8'hEE, 1'b0, "R3 no ack later byte");
        bus_stop();
        read_from(8'h20, "R3 read setup");
        read_byte(1'b0, 8'h42, "R3 location unchanged");
        bus_stop();

        // R10: power fail while slave holds ACK low
        bus_start();
        for (int i = 7; i >= 0; i--) bit_out(dut_addr_bit(i));
        sda_m = 1'b1; half();
        scl = 1'b1; repeat (2) @(negedge clk);
        check("R2 ack before power fail", 1, int'(sda_bus == 1'b0));
        pwr_fail = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 released on power fail", 0, int'(sda_oe));
        scl = 1'b0; half();
        pwr_fail = 1'b0; half();
        bus_stop();

        // R11: power fail mid data byte
        set_ptr(8'h30, "R11 setup");
        write_byte(8'h55, 1'b1, "R11 setup data");
        bus_stop();
        set_ptr(8'h30, "R11 pointer");
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b0); bit_out(1'b1);
        pwr_fail = 1'b1;
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b0); bit_out(1'b1);
        sda_m = 1'b1; half();
        scl = 1'b1; repeat (2) @(negedge clk);
        check("R11 no ack during power fail", 0, int'(sda_bus == 1'b0));
        repeat (2) @(negedge clk);
        scl = 1'b0; half();
        pwr_fail = 1'b0; half();
        bus_stop();

        // R11: whole transfer during power fail
        pwr_fail = 1'b1;
        bus_start();
        write_byte(8'hD0, 1'b0, "R11 address ignored");
        write_byte(8'h30, 1'b0, "R11 pointer ignored");
        write_byte(8'hAA, 1'b0, "R11 data ignored");
        bus_stop();
        pwr_fail = 1'b0; half();
        read_from(8'h30, "R11 read setup");
        read_byte(1'b0, 8'h55, "R11 location unchanged");
        bus_stop();

        // R10: pointer reset, read with no pointer write
        pwr_fail = 1'b1; half();
        pwr_fail = 1'b0; half();
        bus_start();
        write_byte(8'hD1, 1'b1, "R10 read address");
        read_byte(1'b0, 8'h33, "R10 pointer back at 0");
        bus_stop();

        repeat (10) @(negedge clk);
        if (exp_val.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_val.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic dut_addr_bit(input int i);
        logic [7:0] a;
        a = 8'hD0;
        return a[i];
    endfunction

endmodule